// File: doc/BRIEF.md
# Data Object Exchange Discovery Responder

This block sits behind the Data Object Exchange extended capability of a PCIe endpoint and answers the one request it understands: a discovery query. Software streams the request dwords into a write-mailbox register and then sets the GO bit in the control register. It polls the status register until a response object is ready. It then reads the response through the read-mailbox register. Each write of any value to the read mailbox acknowledges the current response dword and moves on to the next.

Requests are checked when GO is seen. A header whose vendor ID is the PCI-SIG value (1) and whose object type is discovery (0) gets a fixed three-dword reply. That reply echoes the request header, gives a length of 3 dwords, and names exactly one protocol (CMA, value 1) with next-index 0, so the list ends there. Any other header puts the mailbox into an error state. An ABORT bit in the control register restarts everything.

All access goes through a single capability-relative register port. Reads return their data one clock after the access.

Top module: `doe_mbx_responder`

## Requirements
- R1: After reset, the status register (offset 0x0C) reads 0 and the read mailbox (offset 0x14) reads 0.
- R2: Each write to the write mailbox (offset 0x10) appends one dword to a request buffer of DEPTH (default 1024) dwords. Writes past DEPTH are dropped, so request dword 0 is never overwritten before an ABORT.
- R3: A write to control (offset 0x08) with GO (bit 31) set, when request dword 0 has a vendor ID (bits 15:0) other than 1 or a type (bits 23:16) other than 0, sets the remaining count to -1. Status then reads 0x4 (error, bit 2), and the read mailbox reads 0.
- R4: GO on a valid discovery header sets the remaining count to 3. Status then reads 0x8000_0000 (object ready, bit 31). The response dwords are: request dword 0; then 0x0000_0003; then 0x0001_0001 (vendor 1 in bits 15:0, protocol 1 in bits 23:16, next-index 0 in bits 31:24). The discovery index in request dword 2 has no effect on the reply.
- R5: A write of any value to the read mailbox while the count is positive decrements the count and advances the read index. When the count is zero or negative, such a write changes neither the status nor the read data.
- R6: Reading the read mailbox returns the dword at the current read index while the count is positive, and 0 otherwise. A read never advances the index.
- R7: ABORT (control bit 0) clears the write index, the read index and the count. When GO and ABORT are set in the same write, ABORT wins and status reads 0.
- R8: GO does not reset the write index or the read index. A second GO without ABORT makes status ready again, and read-mailbox reads at an index past dword 2 return 0.
- R9: Reads of offsets other than status and read mailbox return 0. Writes to unmapped offsets have no effect.
- R10: Read data appears on `cfg_rdata` in the cycle after the read access and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Capability-relative byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the access |

## Verification
The hardest state to reach is a write index that is already saturated. Getting there takes more than DEPTH mailbox writes without an ABORT. The bench performs over a thousand writes that follow a valid header and then issues GO, so a buffer that wrapped around would corrupt the echoed header. A second subtle state is a read index past the end of the reply while the count is positive again. The bench reaches it by issuing GO twice with no ABORT in between. Random traffic then mixes headers, GO, ABORT and acknowledgements against a reference model.

// File: rtl/doe_mbx_pkg.sv
package doe_mbx_pkg;
    localparam int unsigned OFS_CTRL = 'h08;
    localparam int unsigned OFS_STAT = 'h0C;
    localparam int unsigned OFS_WMB  = 'h10;
    localparam int unsigned OFS_RMB  = 'h14;

    localparam int unsigned CTRL_ABORT_BIT = 0;
    localparam int unsigned CTRL_GO_BIT    = 31;
    localparam int unsigned STAT_ERR_BIT   = 2;
    localparam int unsigned STAT_RDY_BIT   = 31;

    localparam logic [15:0] SIG_VID    = 16'h0001;
    localparam logic [7:0]  DISC_TYPE  = 8'h00;
    localparam logic [7:0]  CMA_PROT   = 8'h01;
    localparam logic [31:0] RSP_LENGTH = 32'd3;

    // single discovery entry: next-index | protocol | vendor
    function automatic logic [31:0] disc_entry();
        return {8'h00, CMA_PROT, SIG_VID};
    endfunction
endpackage

// File: rtl/doe_req_capture.sv
module doe_req_capture #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        clear,
    input  logic [31:0] wdata,
    output logic [31:0] hdr0
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [31:0]      hdr0;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.idx = '0;
        end else if (push && (st_q.idx < IDX_W'(DEPTH))) begin
            if (st_q.idx == '0) st_d.hdr0 = wdata;
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr0 = st_q.hdr0;

    // R2
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_W'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && st_q.idx == IDX_W'(DEPTH)) |=> $stable(st_q.hdr0));
endmodule

// File: rtl/doe_resp_engine.sv
module doe_resp_engine
    import doe_mbx_pkg::*;
#(
    parameter int unsigned RIDX_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        abort,
    input  logic        ack,
    input  logic [31:0] hdr0,
    output logic        ready,
    output logic        error,
    output logic [31:0] rsp_word
);
    typedef struct packed {
        logic [2:0]        cnt;   // two's complement, -1..3
        logic [RIDX_W-1:0] ridx;
        logic [31:0]       rsp0;
    } eng_t;

    eng_t st_d, st_q;
    logic hdr_ok;
    logic [31:0] sel_word;

    assign ready  = !st_q.cnt[2] && (st_q.cnt != 3'b000);
    assign error  = st_q.cnt[2];
    assign hdr_ok = (hdr0[15:0] == SIG_VID) && (hdr0[23:16] == DISC_TYPE);

    always_comb begin
        st_d = st_q;
        if (go) begin
            if (hdr_ok) begin
                st_d.cnt  = 3'd3;
                st_d.rsp0 = hdr0;
            end else begin
                st_d.cnt  = 3'b111;
            end
        end
        if (abort) begin
            st_d.cnt  = 3'b000;
            st_d.ridx = '0;
        end
        if (ack && ready) begin
            st_d.cnt = st_q.cnt - 3'd1;
            if (st_q.ridx != '1) st_d.ridx = st_q.ridx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.ridx)
            RIDX_W'(0): sel_word = st_q.rsp0;
            RIDX_W'(1): sel_word = RSP_LENGTH;
            RIDX_W'(2): sel_word = disc_entry();
            default:    sel_word = '0;
        endcase
        rsp_word = ready ? sel_word : '0;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.cnt[2] && st_q.cnt != 3'b111));

    // R5
    ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ready) |=> (st_q.cnt == $past(st_q.cnt) - 3'd1));

    // R5
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ready && !go && !abort) |=> $stable(st_q.cnt));

    // R7
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!ready && !error && st_q.ridx == '0));
endmodule

// File: rtl/doe_mbx_responder.sv
module doe_mbx_responder
    import doe_mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned RIDX_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata
);
    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic wr_ctrl, wr_wmb, wr_rmb, rd_acc, mapped;
    logic go, abort, ready, error;
    logic [31:0] hdr0, rsp_word;

    assign wr_ctrl = cfg_en && cfg_we && (cfg_addr == ADDR_W'(OFS_CTRL));
    assign wr_wmb  = cfg_en && cfg_we && (cfg_addr == ADDR_W'(OFS_WMB));
    assign wr_rmb  = cfg_en && cfg_we && (cfg_addr == ADDR_W'(OFS_RMB));
    assign rd_acc  = cfg_en && !cfg_we;
    assign mapped  = (cfg_addr == ADDR_W'(OFS_STAT)) || (cfg_addr == ADDR_W'(OFS_RMB));
    assign go      = wr_ctrl && cfg_wdata[CTRL_GO_BIT];
    assign abort   = wr_ctrl && cfg_wdata[CTRL_ABORT_BIT];

    doe_req_capture #(.DEPTH(DEPTH)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_wmb),
        .clear (abort),
        .wdata (cfg_wdata),
        .hdr0  (hdr0)
    );

    doe_resp_engine #(.RIDX_W(RIDX_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .abort    (abort),
        .ack      (wr_rmb),
        .hdr0     (hdr0),
        .ready    (ready),
        .error    (error),
        .rsp_word (rsp_word)
    );

    always_comb begin
        rd_d.rdata = '0;
        if (rd_acc) begin
            if (cfg_addr == ADDR_W'(OFS_STAT)) begin
                rd_d.rdata[STAT_RDY_BIT] = ready;
                rd_d.rdata[STAT_ERR_BIT] = error;
            end else if (cfg_addr == ADDR_W'(OFS_RMB)) begin
                rd_d.rdata = rsp_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign cfg_rdata = rd_q.rdata;

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !mapped) |=> (cfg_rdata == '0));

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> (cfg_rdata == '0));

    // R6
    read_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && ready) |=> $stable(rsp_word));
endmodule

// File: tb/doe_mbx_responder_tb.sv
module doe_mbx_responder_tb;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int          m_cnt = 0, m_ridx = 0, m_widx = 0;
    logic [31:0] m_h0 = '0, m_rsp0 = '0;

    always #4 clk = ~clk;   // 125 MHz

    doe_mbx_responder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [31:0] exp_rmb();
        if (m_cnt <= 0)  return 32'h0;
        if (m_ridx == 0) return m_rsp0;
        if (m_ridx == 1) return 32'h0000_0003;
        if (m_ridx == 2) return 32'h0001_0001;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_stat();
        if (m_cnt > 0) return 32'h8000_0000;
        if (m_cnt < 0) return 32'h0000_0004;
        return 32'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
        case (a)
            8'h10: begin
                if (m_widx < DEPTH) begin
                    if (m_widx == 0) m_h0 = d;
                    m_widx++;
                end
            end
            8'h08: begin
                if (d[31]) begin
                    if (m_h0[15:0] == 16'h0001 && m_h0[23:16] == 8'h00) begin
                        m_cnt = 3; m_rsp0 = m_h0;
                    end else m_cnt = -1;
                end
                if (d[0]) begin m_cnt = 0; m_ridx = 0; m_widx = 0; end
            end
            8'h14: if (m_cnt > 0) begin m_cnt--; m_ridx++; end
            default: ;
        endcase
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        logic [31:0] e;
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        e = (a == 8'h0C) ? exp_stat() : (a == 8'h14) ? exp_rmb() : 32'h0;
        @(negedge clk);
        cfg_en = 1'b0;
        chk(req, cfg_rdata, e);
        // R10: data lasts one cycle only
        @(negedge clk);
        chk("R10", cfg_rdata, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd("R1", 8'h0C);
        rd("R1", 8'h14);

        // valid discovery, index 5 ignored
        wr(8'h10, 32'h0000_0001);
        wr(8'h10, 32'h0000_0003);
        wr(8'h10, 32'h0000_0005);
        wr(8'h08, 32'h8000_0000);
        rd("R4", 8'h0C);
        rd("R6", 8'h14);
        rd("R6", 8'h14);
        wr(8'h14, 32'h0);
        rd("R4", 8'h14);
        wr(8'h14, 32'hDEAD_BEEF);
        rd("R4", 8'h14);
        wr(8'h14, 32'h0);
        rd("R5", 8'h0C);
        rd("R5", 8'h14);
        wr(8'h14, 32'h0);
        rd("R5", 8'h0C);

        // second GO without ABORT: index already past the reply
        wr(8'h08, 32'h8000_0000);
        rd("R8", 8'h0C);
        rd("R8", 8'h14);
        repeat (3) wr(8'h14, 32'h0);
        rd("R8", 8'h0C);

        // bad vendor, then bad type
        wr(8'h08, 32'h0000_0001);
        wr(8'h10, 32'h0000_0002);
        wr(8'h08, 32'h8000_0000);
        rd("R3", 8'h0C);
        rd("R3", 8'h14);
        wr(8'h14, 32'h0);
        rd("R5", 8'h0C);
        wr(8'h08, 32'h0000_0001);
        wr(8'h10, 32'h0001_0001);
        wr(8'h08, 32'h8000_0000);
        rd("R3", 8'h0C);

        // GO and ABORT together
        wr(8'h08, 32'h0000_0001);
        wr(8'h10, 32'h0000_0001);
        wr(8'h08, 32'h8000_0001);
        rd("R7", 8'h0C);

        // overflow of the request buffer
        wr(8'h08, 32'h0000_0001);
        wr(8'h10, 32'h00AB_0001 & 32'hFF00_FFFF);
        for (int i = 0; i < DEPTH + 4; i++) wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h08, 32'h8000_0000);
        rd("R2", 8'h0C);
        rd("R2", 8'h14);

        // unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd("R9", 8'h00);
        rd("R9", 8'h08);
        rd("R9", 8'h10);
        rd("R9", 8'h18);
        rd("R9", 8'h0C);

        // constrained random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int unsigned k;
            k = $urandom_range(0, 9);
            case (k)
                0, 1: begin
                    if ($urandom_range(0, 1) == 1)
                        wr(8'h10, {$urandom_range(0, 255) == 0 ? 8'h01 : 8'h00,
                                   8'h00, 16'h0001});
                    else
                        wr(8'h10, $urandom);
                end
                2: wr(8'h08, 32'h8000_0000);
                3: wr(8'h08, ($urandom_range(0, 3) == 0) ? 32'h8000_0001 : 32'h0000_0001);
                4, 5: wr(8'h14, $urandom);
                6, 7: rd("R4", 8'h14);
                8: rd("R5", 8'h0C);
                default: rd("R9", 8'($urandom_range(0, 7) * 4));
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule